// File: doc/BRIEF.md
# Overcurrent Threshold Interrupt Flag

This block watches the current samples of three line phases and raises a sticky overcurrent flag whenever an enabled phase exceeds a programmable 8-bit level. Each sample is a 24-bit two's-complement value. The block takes its absolute value and compares the field of magnitude bits 21 down to 14 against the level. The encoding is chosen so that a full-scale sample (0x2851EC) has a field of 0xA1.

The flag appears at bit 15 of a 16-bit status word. When the interrupt enable is set, the flag also drives an active-low interrupt line low. Software clears the flag with a read-with-reset access to the status word. A plain read leaves the flag as it is. Phase selection is a 3-bit mask, so any combination of phases can be monitored at once.

Top module: `oc_irq_flag`

## Requirements
- R1: The 8-bit level is compared against magnitude bits 21..14. The compare is strictly greater-than: a field equal to the level does not set the flag.
- R2: A cycle with `smp_vld` high where an enabled phase exceeds the level sets the flag, and the flag is visible one clock later. Samples presented with `smp_vld` low have no effect.
- R3: Bit k of `ph_en` enables phase k (bit 0 = `ph0_smp`, bit 1 = `ph1_smp`, bit 2 = `ph2_smp`). A disabled phase never sets the flag, whatever its value. Several phases may be enabled together, and their results are ORed.
- R4: Once set, the flag stays set until a read-with-reset.
- R5: A `stat_rd_clr` pulse clears the flag at the next clock. If an exceedance arrives in the same cycle, the flag stays set.
- R6: A `stat_rd` pulse without `stat_rd_clr` leaves the flag unchanged.
- R7: `status` carries the flag at bit 15, and all other bits read 0.
- R8: `irq_n` is 0 exactly when the flag is set and `irq_en` is 1. With `irq_en` at 0, `irq_n` stays 1 while the flag still records events.
- R9: Magnitude is the two's-complement absolute value, and negative samples use their magnitude. A magnitude with bit 22 or bit 23 set (including -2^23) exceeds every level.
- R10: During and just after reset the flag is 0, `irq_n` is 1 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Samples valid this cycle |
| ph0_smp | input | 24 | Phase 0 signed current sample |
| ph1_smp | input | 24 | Phase 1 signed current sample |
| ph2_smp | input | 24 | Phase 2 signed current sample |
| ph_en | input | 3 | Per-phase monitor enable |
| oc_level | input | 8 | Overcurrent level (magnitude bits 21..14) |
| irq_en | input | 1 | Interrupt mask enable for the flag |
| stat_rd | input | 1 | Plain status read strobe |
| stat_rd_clr | input | 1 | Read-with-reset status strobe |
| status | output | 16 | Status word, flag at bit 15 |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the strobes and the level are synchronous to `clk` and are free of X after reset. They also assume that `stat_rd_clr` may coincide with a valid sample, and that this case is intended. The stimulus drives every input on the falling edge from bench tasks, so nothing changes near the sampling edge. Random fields are built around the level (level-1, level, level+1) so that the equality boundary is hit often. Directed vectors add full scale, the most negative sample, a disabled phase at large magnitude, and a clear that collides with a new exceedance.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef struct packed {
        logic flag;
    } oc_state_t;

    function automatic logic [23:0] mag24(input logic [23:0] s);
        return s[23] ? (~s + 24'd1) : s;
    endfunction

endpackage

// File: rtl/oc_mag.sv
module oc_mag #(
    parameter int SMP_W = 24,
    parameter int LVL_W = 8,
    parameter int LSB   = 14
) (
    input  logic [SMP_W-1:0] smp,
    output logic [LVL_W-1:0] level,
    output logic             over
);
    localparam int TOP = LSB + LVL_W;

    logic [SMP_W-1:0] mag_d;

    always_comb begin
        mag_d = smp[SMP_W-1] ? (~smp + {{(SMP_W-1){1'b0}}, 1'b1}) : smp;
        level = mag_d[TOP-1:LSB];
        over  = |mag_d[SMP_W-1:TOP];
    end

`ifndef SYNTHESIS
    AST_MAG_NONNEG: assert final (smp[SMP_W-1] == 1'b0 || smp == {1'b1, {(SMP_W-1){1'b0}}} || mag_d[SMP_W-1] == 1'b0 || $isunknown(smp)); // R9
`endif
endmodule

// File: rtl/oc_cmp.sv
module oc_cmp #(
    parameter int N_PH  = 3,
    parameter int LVL_W = 8
) (
    input  logic                       smp_vld,
    input  logic [N_PH-1:0]            ph_en,
    input  logic [N_PH-1:0][LVL_W-1:0] levels,
    input  logic [N_PH-1:0]            over,
    input  logic [LVL_W-1:0]           thr,
    output logic                       hit
);
    logic [N_PH-1:0] ph_hit_d;

    for (genvar k = 0; k < N_PH; k++) begin : g_ph
        always_comb ph_hit_d[k] = ph_en[k] && (over[k] || (levels[k] > thr));
    end

    always_comb hit = smp_vld && (|ph_hit_d);

    always_comb begin
        if (!smp_vld) AST_NO_HIT_IDLE: assert (!hit); // R2
        if (ph_en == '0) AST_NO_HIT_DISABLED: assert (!hit); // R3
    end
endmodule

// File: rtl/oc_flag.sv
module oc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_clr,
    output logic flag
);
    import oc_pkg::*;

    oc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) st_d.flag = 1'b0;
        if (hit)    st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb flag = st_q.flag;

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_clr) |=> flag); // R4
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !hit) |=> !flag); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hit) |=> !flag); // R2
endmodule

// File: rtl/oc_irq_flag.sv
module oc_irq_flag #(
    parameter int SMP_W    = 24,
    parameter int LVL_W    = 8,
    parameter int LSB      = 14,
    parameter int STAT_W   = 16,
    parameter int FLAG_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  ph0_smp,
    input  logic [SMP_W-1:0]  ph1_smp,
    input  logic [SMP_W-1:0]  ph2_smp,
    input  logic [2:0]        ph_en,
    input  logic [LVL_W-1:0]  oc_level,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic              stat_rd_clr,
    output logic [STAT_W-1:0] status,
    output logic              irq_n
);
    localparam int N_PH = 3;

    logic [N_PH-1:0][SMP_W-1:0] smp_arr;
    logic [N_PH-1:0][LVL_W-1:0] lvl_arr;
    logic [N_PH-1:0]            over_arr;
    logic                       hit;
    logic                       flag;

    always_comb begin
        smp_arr[0] = ph0_smp;
        smp_arr[1] = ph1_smp;
        smp_arr[2] = ph2_smp;
    end

    for (genvar k = 0; k < N_PH; k++) begin : g_mag
        oc_mag #(.SMP_W(SMP_W), .LVL_W(LVL_W), .LSB(LSB)) u_mag (
            .smp   (smp_arr[k]),
            .level (lvl_arr[k]),
            .over  (over_arr[k])
        );
    end

    oc_cmp #(.N_PH(N_PH), .LVL_W(LVL_W)) u_cmp (
        .smp_vld (smp_vld),
        .ph_en   (ph_en),
        .levels  (lvl_arr),
        .over    (over_arr),
        .thr     (oc_level),
        .hit     (hit)
    );

    oc_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .rd_clr (stat_rd_clr),
        .flag   (flag)
    );

    always_comb begin
        status           = '0;
        status[FLAG_BIT] = flag;
        irq_n            = !(flag && irq_en);
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n); // R8
    AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) <= 1); // R7
    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_rd_clr && status[FLAG_BIT]) |=> status[FLAG_BIT]); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (irq_n && status == '0)); // R10
endmodule

// File: tb/tb_oc_irq_flag.sv
module tb_oc_irq_flag;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [23:0] ph0_smp = '0, ph1_smp = '0, ph2_smp = '0;
    logic [2:0]  ph_en = '0;
    logic [7:0]  oc_level = '0;
    logic        irq_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic        stat_rd_clr = 1'b0;
    logic [15:0] status;
    logic        irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit exp_flag = 1'b0;
    bit cur_ien = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    oc_irq_flag dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .ph0_smp(ph0_smp), .ph1_smp(ph1_smp), .ph2_smp(ph2_smp),
        .ph_en(ph_en), .oc_level(oc_level), .irq_en(irq_en),
        .stat_rd(stat_rd), .stat_rd_clr(stat_rd_clr),
        .status(status), .irq_n(irq_n)
    );

    function automatic bit exceeds(input logic [23:0] s, input logic [7:0] thr);
        logic [24:0] m;
        m = s[23] ? (25'd0 - {s[23], s}) : {1'b0, s};
        return (m[23:22] != 2'b00) || (m[21:14] > thr);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag);
        chk(tag, {31'd0, status[15]}, {31'd0, exp_flag});
        chk("R7", {17'd0, status[14:0]}, 32'd0);
        chk("R8", {31'd0, irq_n}, {31'd0, !(exp_flag && cur_ien)});
    endtask

    task automatic step(input bit vld, input logic [23:0] a, input logic [23:0] b,
                        input logic [23:0] c, input logic [2:0] en, input logic [7:0] thr,
                        input bit ien, input bit clr, input bit rd, input string tag);
        bit ex;
        smp_vld = vld; ph0_smp = a; ph1_smp = b; ph2_smp = c;
        ph_en = en; oc_level = thr; irq_en = ien; stat_rd_clr = clr; stat_rd = rd;
        ex = vld && ((en[0] && exceeds(a, thr)) || (en[1] && exceeds(b, thr)) ||
                     (en[2] && exceeds(c, thr)));
        exp_flag = (exp_flag && !clr) || ex;
        cur_ien = ien;
        @(negedge clk);
        check_out(tag);
    endtask

    function automatic logic [23:0] near(input logic [7:0] thr);
        logic [7:0] f;
        logic [23:0] s;
        case ($urandom_range(0, 2))
            0: f = thr - 8'd1;
            1: f = thr;
            default: f = thr + 8'd1;
        endcase
        s = {2'b00, f, 14'($urandom)};
        if ($urandom_range(0, 1) == 1) s = 24'd0 - s;
        return s;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C1A_5EED));
        repeat (3) @(negedge clk);
        check_out("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R10");

        // R1: full scale field 0xA1 against equal and lower level
        step(1, 24'h2851EC, 0, 0, 3'b001, 8'hA1, 1, 0, 0, "R1");
        step(1, 24'h2851EC, 0, 0, 3'b001, 8'hA0, 1, 0, 0, "R1");
        // R6: plain read keeps it
        step(0, 0, 0, 0, 3'b111, 8'hFF, 1, 0, 1, "R6");
        // R4: sticky through idle
        step(0, 0, 0, 0, 3'b111, 8'hFF, 1, 0, 0, "R4");
        // R5: clear
        step(0, 0, 0, 0, 3'b111, 8'hFF, 1, 1, 1, "R5");
        // R3: disabled phase at max magnitude
        step(1, 0, 24'h7FFFFF, 0, 3'b101, 8'h00, 1, 0, 0, "R3");
        // R3: only phase 2 enabled, exceeding
        step(1, 0, 0, 24'h3FC000, 3'b100, 8'hFE, 1, 0, 0, "R3");
        // R5: clear colliding with a new exceedance keeps flag
        step(1, 24'hF00000, 0, 0, 3'b001, 8'h10, 1, 1, 1, "R5");
        step(0, 0, 0, 0, 3'b000, 8'h00, 1, 1, 1, "R5");
        // R9: most negative sample exceeds level 0xFF
        step(1, 24'h800000, 0, 0, 3'b001, 8'hFF, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 3'b000, 8'h00, 1, 1, 1, "R5");
        // R9: magnitude bit 22 exceeds 0xFF
        step(1, 0, 24'hC00000, 0, 3'b010, 8'hFF, 0, 0, 0, "R9");
        // R8: masked, flag recorded, irq high
        step(0, 0, 0, 0, 3'b000, 8'h00, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 3'b000, 8'h00, 0, 1, 1, "R5");
        // R2: invalid sample ignored
        step(0, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 3'b111, 8'h00, 1, 0, 0, "R2");
        // R1: negative equal field does not set
        step(1, 24'd0 - 24'h04_0000, 0, 0, 3'b001, 8'h10, 1, 0, 0, "R1");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] thr;
            logic [2:0] en;
            bit vld, clr, rd, ien, ex;
            string tag;
            thr = 8'($urandom);
            en  = 3'($urandom);
            vld = ($urandom_range(0, 3) != 0);
            clr = ($urandom_range(0, 5) == 0);
            rd  = ($urandom_range(0, 4) == 0);
            ien = ($urandom_range(0, 3) != 0);
            begin
                logic [23:0] a, b, c;
                a = ($urandom_range(0, 7) == 0) ? 24'($urandom) : near(thr);
                b = ($urandom_range(0, 7) == 0) ? 24'($urandom) : near(thr);
                c = ($urandom_range(0, 7) == 0) ? 24'($urandom) : near(thr);
                ex = vld && ((en[0] && exceeds(a, thr)) || (en[1] && exceeds(b, thr)) ||
                             (en[2] && exceeds(c, thr)));
                if (clr)           tag = "R5";
                else if (ex)       tag = "R2";
                else if (exp_flag) tag = rd ? "R6" : "R4";
                else               tag = (en != 3'b111) ? "R3" : "R1";
                step(vld, a, b, c, en, thr, ien, clr, rd, tag);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule